// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Interrupt Routing

This block watches the running calendar time of a real-time clock and compares it with two alarm banks. Each bank holds four byte fields: seconds, minutes, hours and weekday. Setting the top bit of an alarm field turns that field into a wildcard. When every field of a bank either matches the current time or is a wildcard, the match is sampled on the seconds-update strobe and sets that alarm's pending flag.

The pending flags drive two active-low interrupt lines, and each flag is gated by its own enable bit. A routing input decides how alarm 1 is wired. In one setting it shares line 0 with alarm 0. In the other it owns line 1. The register interface clears pending flags in two ways. A read of an alarm bank acknowledges that alarm. A status write clears every flag whose written bit is zero.

The hours field is compared as the full encoded byte, so the alarm must use the same 12/24-hour encoding as the time keeper.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset both pending flags are 0 and both interrupt outputs (`irq0_n`, `irq1_n`) are 1.
- R2: An alarm field matches when its bit 7 is 1 (wildcard) or when its bits 6:0 equal bits 6:0 of the current field. Field byte order in the packed buses is seconds [7:0], minutes [15:8], hours [23:16], weekday [31:24]. When `sec_tick` is 1 and all four fields of bank i match, `flags[i]` is 1 from the next clock cycle on.
- R3: A pending flag never rises in a cycle that follows one where `sec_tick` was 0.
- R4: The hours byte is compared in full encoding. Bit 6 marks 12-hour format and bit 5 marks PM, so a 12-hour alarm value 0x52 does not match a 24-hour time 0x12.
- R5: A pulse on `bank_rd[i]` clears `flags[i]` in the next cycle and leaves the other flag unchanged.
- R6: A pulse on `stat_wr` clears each `flags[i]` whose `stat_wdata[i]` is 0. A flag whose written bit is 1 keeps its value.
- R7: When a match event and a clear of the same alarm fall in the same cycle, the flag ends up set.
- R8: `irq0_n` is 0 exactly when (`flags[0]` and `irq_en[0]`) is true, or when (`route_split`=0 and `flags[1]` and `irq_en[1]`) is true.
- R9: With `route_split`=1, `irq1_n` is 0 exactly when `flags[1]` and `irq_en[1]` are both 1. With `route_split`=0, `irq1_n` stays 1.
- R10: Dropping an enable bit releases the interrupt line in the same cycle without clearing the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe when the seconds field updates |
| cur_time | input | 32 | Current BCD time: sec, min, hour, weekday bytes |
| alm0_cfg | input | 32 | Alarm bank 0 fields, same packing |
| alm1_cfg | input | 32 | Alarm bank 1 fields, same packing |
| irq_en | input | 2 | Per-alarm interrupt enables |
| route_split | input | 1 | 1: alarm 1 on line 1; 0: both alarms on line 0 |
| bank_rd | input | 2 | Per-bank read strobe (acknowledge) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 2 | Status write data; 0 bits clear flags |
| flags | output | 2 | Pending alarm flags |
| irq0_n | output | 1 | Interrupt line 0, active low |
| irq1_n | output | 1 | Interrupt line 1, active low |

## Verification
The bench uses the default parameters: 8-bit fields, four fields per bank and the wildcard on bit 7. These match the register encoding, so every wildcard combination and the 12-hour and PM hour bits can be reached. Random current times are drawn from a small pool, and alarm fields are biased toward copies of the current time or toward wildcards. This makes matches common, and collisions of a match with either clear path occur often. Directed cases add the hour-encoding mismatch and both routing settings.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
   typedef enum logic {
      ROUTE_SHARED = 1'b0,
      ROUTE_SPLIT  = 1'b1
   } route_e;

   localparam int unsigned NUM_ALARMS = 2;
endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned NUM_FIELDS = 4,
   parameter int unsigned MASK_BIT   = 7
) (
   input  logic [NUM_FIELDS*FIELD_W-1:0] cur,
   input  logic [NUM_FIELDS*FIELD_W-1:0] cfg,
   output logic                          hit
);
   localparam int unsigned CMP_W = MASK_BIT;

   if (MASK_BIT >= FIELD_W) begin : g_bad_mask
      $error("MASK_BIT must lie inside the field");
   end
   if (NUM_FIELDS < 1) begin : g_bad_fields
      $error("NUM_FIELDS must be at least 1");
   end

   logic [NUM_FIELDS-1:0] field_ok;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
      logic [FIELD_W-1:0] c_f, a_f;
      assign c_f = cur[f*FIELD_W +: FIELD_W];
      assign a_f = cfg[f*FIELD_W +: FIELD_W];
      assign field_ok[f] = a_f[MASK_BIT] | (a_f[CMP_W-1:0] == c_f[CMP_W-1:0]);
   end

   assign hit = &field_ok;
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (!rst_n)      flag <= 1'b0;
      else if (set)    flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
   end

   assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (set && clr) |=> flag);
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
   assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !set |=> !$rose(flag));
endmodule

// File: rtl/rtc_alarm_route.sv
module rtc_alarm_route
   import rtc_alarm_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_ALARMS-1:0] flags,
   input  logic [NUM_ALARMS-1:0] en,
   input  route_e                route,
   output logic                  irq0_n,
   output logic                  irq1_n
);
   logic [NUM_ALARMS-1:0] live;
   assign live = flags & en;

   always_comb begin
      irq0_n = 1'b1;
      irq1_n = 1'b1;
      if (live[0]) irq0_n = 1'b0;
      if (live[1]) begin
         if (route == ROUTE_SPLIT) irq1_n = 1'b0;
         else                      irq0_n = 1'b0;
      end
   end

   assert_shared_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (route == ROUTE_SHARED) |-> irq1_n);
   assert_a0_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && en[0]) |-> !irq0_n);
   assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> (irq0_n && irq1_n));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned FIELD_W    = 8,
   parameter int unsigned NUM_FIELDS = 4,
   parameter int unsigned MASK_BIT   = 7,
   localparam int unsigned BANK_W    = FIELD_W * NUM_FIELDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic [BANK_W-1:0] cur_time,
   input  logic [BANK_W-1:0] alm0_cfg,
   input  logic [BANK_W-1:0] alm1_cfg,
   input  logic [1:0]        irq_en,
   input  logic              route_split,
   input  logic [1:0]        bank_rd,
   input  logic              stat_wr,
   input  logic [1:0]        stat_wdata,
   output logic [1:0]        flags,
   output logic              irq0_n,
   output logic              irq1_n
);
   logic [BANK_W-1:0]     bank_cfg [NUM_ALARMS];
   logic [NUM_ALARMS-1:0] hit, set_ev, clr_ev;

   assign bank_cfg[0] = alm0_cfg;
   assign bank_cfg[1] = alm1_cfg;

   for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
      rtc_alarm_match #(
         .FIELD_W   (FIELD_W),
         .NUM_FIELDS(NUM_FIELDS),
         .MASK_BIT  (MASK_BIT)
      ) u_match (
         .cur(cur_time),
         .cfg(bank_cfg[i]),
         .hit(hit[i])
      );

      assign set_ev[i] = sec_tick & hit[i];
      assign clr_ev[i] = bank_rd[i] | (stat_wr & ~stat_wdata[i]);

      rtc_alarm_flag u_flag (
         .clk  (clk),
         .rst_n(rst_n),
         .set  (set_ev[i]),
         .clr  (clr_ev[i]),
         .flag (flags[i])
      );
   end

   rtc_alarm_route u_route (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flags),
      .en    (irq_en),
      .route (route_e'(route_split)),
      .irq0_n(irq0_n),
      .irq1_n(irq1_n)
   );

   assert_split_line1_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (route_split && flags[1] && irq_en[1]) |-> !irq1_n);
   assert_rd_other_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_rd == 2'b01 && !stat_wr && flags[1]) |=> flags[1]);
endmodule

// File: tb/rtc_alarm_irq_tb.sv
module rtc_alarm_irq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sec_tick = 1'b0;
   logic [31:0] cur_time = '0, alm0_cfg = '0, alm1_cfg = '0;
   logic [1:0]  irq_en = '0, bank_rd = '0, stat_wdata = '0;
   logic        route_split = 1'b0, stat_wr = 1'b0;
   logic [1:0]  flags;
   logic        irq0_n, irq1_n;

   int checks = 0, errors = 0;
   logic [1:0] fm = '0;   // model of pending flags
   bit done = 0;

   always #2 clk = ~clk;

   rtc_alarm_irq u_dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_time(cur_time),
      .alm0_cfg(alm0_cfg), .alm1_cfg(alm1_cfg), .irq_en(irq_en),
      .route_split(route_split), .bank_rd(bank_rd), .stat_wr(stat_wr),
      .stat_wdata(stat_wdata), .flags(flags), .irq0_n(irq0_n), .irq1_n(irq1_n)
   );

   function automatic bit bank_hit(logic [31:0] t, logic [31:0] a);
      bit ok = 1;
      for (int f = 0; f < 4; f++)
         if (!a[f*8+7] && (a[f*8 +: 7] != t[f*8 +: 7])) ok = 0;
      return ok;
   endfunction

   function automatic logic [1:0] exp_irq(logic [1:0] f, logic [1:0] e, logic r);
      logic l0, l1;
      l0 = !((f[0] & e[0]) | (!r & f[1] & e[1]));
      l1 = !(r & f[1] & e[1]);
      return {l1, l0};
   endfunction

   task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called just after a negedge with inputs already set
   task automatic step(string req);
      logic [1:0] nx;
      #1;
      chk(req, {flags, irq1_n, irq0_n}, {fm, exp_irq(fm, irq_en, route_split)});
      for (int i = 0; i < 2; i++) begin
         bit s, c;
         s = sec_tick && bank_hit(cur_time, i == 0 ? alm0_cfg : alm1_cfg);
         c = bank_rd[i] || (stat_wr && !stat_wdata[i]);
         nx[i] = s ? 1'b1 : (c ? 1'b0 : fm[i]);
      end
      @(posedge clk);
      fm = nx;
      @(negedge clk);
   endtask

   task automatic quiet();
      sec_tick = 0; bank_rd = 0; stat_wr = 0; stat_wdata = 2'b11;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      #1; chk("R1 reset", {flags, irq1_n, irq0_n}, 4'b0011);
      rst_n = 1;
      @(negedge clk);
      step("R1 after reset");

      // R2 wildcard on all fields fires on tick
      quiet(); cur_time = 32'h03_14_25_36; alm0_cfg = 32'h80_80_80_80;
      alm1_cfg = 32'h03_14_25_37; irq_en = 2'b11; route_split = 1;
      step("R3 no tick");
      sec_tick = 1; step("R2 wildcard match");
      quiet(); step("R2 flag0 set, alarm1 mismatch");
      // R4 hour encoding
      cur_time = 32'h02_12_00_00; alm1_cfg = 32'h02_52_00_00; sec_tick = 1;
      step("R4 12h vs 24h hour"); quiet(); step("R4 no set");
      alm1_cfg = 32'h02_12_00_00; sec_tick = 1; step("R2 exact match");
      quiet(); step("R9 split line1");
      // R10 enable drop
      irq_en = 2'b00; step("R10 enables off, flags kept");
      irq_en = 2'b11; route_split = 0; step("R8 shared line0");
      // R5 bank read
      bank_rd = 2'b01; step("R5 read bank0"); quiet(); step("R5 bank1 kept");
      // R7 set beats clear
      sec_tick = 1; bank_rd = 2'b10; step("R7 set vs read");
      quiet(); step("R7 flag1 stays");
      // R6 status write
      stat_wr = 1; stat_wdata = 2'b01; step("R6 write keeps bit0, clears bit1");
      quiet(); step("R6 result");

      for (int n = 0; n < 4000; n++) begin
         logic [7:0] pool [4];
         pool = '{8'h00, 8'h15, 8'h42, 8'h59};
         for (int f = 0; f < 4; f++) cur_time[f*8 +: 8] = pool[$urandom_range(3)];
         for (int b = 0; b < 2; b++)
            for (int f = 0; f < 4; f++) begin
               logic [7:0] v;
               int r = $urandom_range(7);
               v = (r < 5) ? cur_time[f*8 +: 8] :
                   (r < 7) ? (8'h80 | 8'($urandom_range(127))) : pool[$urandom_range(3)];
               if (b == 0) alm0_cfg[f*8 +: 8] = v; else alm1_cfg[f*8 +: 8] = v;
            end
         sec_tick    = $urandom_range(1);
         bank_rd     = ($urandom_range(7) == 0) ? 2'($urandom_range(3)) : 2'b00;
         stat_wr     = ($urandom_range(7) == 0);
         stat_wdata  = 2'($urandom_range(3));
         irq_en      = 2'($urandom_range(3));
         route_split = $urandom_range(1);
         step("R2 R5 R6 R7 R8 R9 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule